// File: doc/BRIEF.md
# Viewport-Programmed Inbound Address Translator

This block translates the addresses of memory requests arriving at a bus endpoint. It holds a set of inbound regions and a set of outbound regions. Software reaches them indirectly: it first writes a selector register that names one region and a direction, then reads or writes that region's window, target and control registers. The same register offsets serve every region.

Each clock cycle a request may arrive with a 64-bit address, a 4-bit transaction-type code and the number of the base address register (BAR) it hit. The block compares it against every enabled inbound region in parallel. A region matches either on an inclusive address window or on a BAR number, and its type code must also match. The lowest-numbered matching region supplies the translated address, which is that region's target plus the request's offset. A request that matches no region passes through unchanged with a miss flag. The result is registered, one cycle after the request.

Outbound regions are stored and can be read back. Their matching logic sits in another part of the endpoint, so they never take part in inbound translation.

Top module: `addr_xlate_unit`

## Requirements
- R1: After reset every region register reads zero, the selector reads zero, every region is disabled and `out_valid`, `out_hit` and `out_miss` are low.
- R2: Selector register (offset 0): bits [3:0] pick the region and bit 31 picks the inbound (1) or outbound (0) bank. It reads back with bits [30:4] zero. Register offsets 1..7 are type, control, base-low, base-high, limit, target-low and target-high, and they access the selected region. A region index beyond the bank size ignores writes and reads zero. Reads are registered, with data one cycle after `reg_rd`.
- R3: The low 16 bits of base-low and of target-low are forced to zero on write and read back as zero. The limit keeps all 32 bits.
- R4: In address mode, a request hits when base <= address <= limit. Here base is {base-high, base-low} and limit is {base-high, limit}. The output address is {target-high, target-low} + (address - base).
- R5: A region hits only when `req_type` equals the type register's bits [3:0].
- R6: Control bit 31 enables the region. A region with this bit clear never produces a hit.
- R7: Control bit 30 set selects BAR mode. In this mode the region hits when `req_bar` equals control bits [10:8], and the output is the target plus address bits [15:0].
- R8: When several enabled inbound regions match, `out_region` and `out_addr` come from the lowest-numbered one.
- R9: A request with no match gives `out_miss`=1 and `out_hit`=0, with `out_addr` equal to the request address.
- R10: `out_valid` equals `req_valid` of the previous cycle. `out_hit` and `out_miss` are low when `out_valid` is low.
- R11: Outbound regions never affect inbound matching, and the two banks are stored separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Request present |
| req_addr | input | 64 | Request address |
| req_type | input | 4 | Request transaction-type code |
| req_bar | input | 3 | BAR number the request hit |
| out_valid | output | 1 | Result valid |
| out_hit | output | 1 | Request matched a region |
| out_miss | output | 1 | Request matched no region |
| out_region | output | 2 | Index of the matching region |
| out_addr | output | 64 | Translated or passed-through address |

## Verification
The translation path is driven with addresses at the first and last byte of a window and one byte outside each end. It is also driven with an address whose upper 32 bits differ from the base, which shows that the comparison spans the full 64 bits. Wrong type codes, a cleared enable, overlapping windows and BAR-mode requests with matching and non-matching BAR numbers each separate one qualifying term of the hit condition from the others. Requests in the window of an enabled outbound region, writes through an out-of-range selector index, and unaligned base and target writes check that the banks are isolated and that alignment is enforced.

// File: rtl/axu_pkg.sv
`timescale 1ns/1ps
package axu_pkg;
   localparam int ADDR_W  = 64;
   localparam int TYPE_W  = 4;
   localparam int BARN_W  = 3;
   localparam int EN_BIT  = 31;
   localparam int MODE_BIT = 30;
   localparam int BAR_LSB = 8;
   localparam int DIR_BIT = 31;

   typedef enum logic [2:0] {
      RA_VIEW    = 3'd0,
      RA_TYPE    = 3'd1,
      RA_CTRL    = 3'd2,
      RA_BASE_LO = 3'd3,
      RA_BASE_HI = 3'd4,
      RA_LIMIT   = 3'd5,
      RA_TGT_LO  = 3'd6,
      RA_TGT_HI  = 3'd7
   } reg_sel_e;

   typedef struct packed {
      logic [31:0]       base_lo;
      logic [31:0]       base_hi;
      logic [31:0]       limit;
      logic [31:0]       tgt_lo;
      logic [31:0]       tgt_hi;
      logic [TYPE_W-1:0] ttype;
      logic              en;
      logic              bar_mode;
      logic [BARN_W-1:0] bar;
   } region_t;
endpackage

// File: rtl/xlate_regfile.sv
`timescale 1ns/1ps
module xlate_regfile
   import axu_pkg::*;
#(
   parameter int NUM_IB     = 4,
   parameter int NUM_OB     = 4,
   parameter int ALIGN_BITS = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic                     reg_rd,
   input  logic [2:0]               reg_addr,
   input  logic [31:0]              reg_wdata,
   output logic [31:0]              reg_rdata,
   output region_t [NUM_IB-1:0]     ib_cfg
);
   localparam logic [31:0] ALIGN_MASK = ~((32'd1 << ALIGN_BITS) - 32'd1);

   reg_sel_e   sel;
   logic       vp_dir_q;
   logic [3:0] vp_idx_q;
   region_t    ib_q [NUM_IB];
   region_t    ob_q [NUM_OB];
   region_t    rd_region;
   logic       rd_ok;

   assign sel = reg_sel_e'(reg_addr);

   function automatic region_t apply_wr(region_t r, reg_sel_e s, logic [31:0] d);
      region_t n;
      n = r;
      case (s)
         RA_TYPE:    n.ttype = d[TYPE_W-1:0];
         RA_CTRL: begin
            n.en       = d[EN_BIT];
            n.bar_mode = d[MODE_BIT];
            n.bar      = d[BAR_LSB +: BARN_W];
         end
         RA_BASE_LO: n.base_lo = d & ALIGN_MASK;
         RA_BASE_HI: n.base_hi = d;
         RA_LIMIT:   n.limit   = d;
         RA_TGT_LO:  n.tgt_lo  = d & ALIGN_MASK;
         RA_TGT_HI:  n.tgt_hi  = d;
         default:    ;
      endcase
      return n;
   endfunction

   function automatic logic [31:0] rd_field(region_t r, reg_sel_e s);
      logic [31:0] v;
      v = '0;
      case (s)
         RA_TYPE:    v[TYPE_W-1:0] = r.ttype;
         RA_CTRL: begin
            v[EN_BIT]            = r.en;
            v[MODE_BIT]          = r.bar_mode;
            v[BAR_LSB +: BARN_W] = r.bar;
         end
         RA_BASE_LO: v = r.base_lo;
         RA_BASE_HI: v = r.base_hi;
         RA_LIMIT:   v = r.limit;
         RA_TGT_LO:  v = r.tgt_lo;
         RA_TGT_HI:  v = r.tgt_hi;
         default:    v = '0;
      endcase
      return v;
   endfunction

   // Selector register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vp_dir_q <= 1'b0;
         vp_idx_q <= '0;
      end else if (reg_wr && sel == RA_VIEW) begin
         vp_dir_q <= reg_wdata[DIR_BIT];
         vp_idx_q <= reg_wdata[3:0];
      end
   end

   // Inbound bank
   for (genvar i = 0; i < NUM_IB; i++) begin : g_ib
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ib_q[i] <= '0;
         else if (reg_wr && sel != RA_VIEW && vp_dir_q && vp_idx_q == 4'(i))
            ib_q[i] <= apply_wr(ib_q[i], sel, reg_wdata);
      end
      assign ib_cfg[i] = ib_q[i];
   end

   // Outbound bank: stored for readback only
   for (genvar j = 0; j < NUM_OB; j++) begin : g_ob
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ob_q[j] <= '0;
         else if (reg_wr && sel != RA_VIEW && !vp_dir_q && vp_idx_q == 4'(j))
            ob_q[j] <= apply_wr(ob_q[j], sel, reg_wdata);
      end
   end

   always_comb begin
      rd_region = '0;
      rd_ok     = 1'b0;
      for (int i = 0; i < NUM_IB; i++)
         if (vp_dir_q && vp_idx_q == 4'(i)) begin
            rd_region = ib_q[i];
            rd_ok     = 1'b1;
         end
      for (int j = 0; j < NUM_OB; j++)
         if (!vp_dir_q && vp_idx_q == 4'(j)) begin
            rd_region = ob_q[j];
            rd_ok     = 1'b1;
         end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reg_rdata <= '0;
      else if (reg_rd) begin
         if (sel == RA_VIEW)
            reg_rdata <= {vp_dir_q, 27'd0, vp_idx_q};
         else if (rd_ok)
            reg_rdata <= rd_field(rd_region, sel);
         else
            reg_rdata <= '0;
      end
   end

   // R2: selector readback carries no reserved bits
   p_vp_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 3'd0) |=> reg_rdata[30:4] == '0);
endmodule

// File: rtl/xlate_region_match.sv
`timescale 1ns/1ps
module xlate_region_match
   import axu_pkg::*;
#(
   parameter int ALIGN_BITS = 16
) (
   input  region_t             cfg,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [TYPE_W-1:0]   req_type,
   input  logic [BARN_W-1:0]   req_bar,
   output logic                hit,
   output logic [ADDR_W-1:0]   xaddr
);
   logic [ADDR_W-1:0] base, lim, tgt, ofs;
   logic              win_ok;

   always_comb begin
      base = {cfg.base_hi, cfg.base_lo};
      lim  = {cfg.base_hi, cfg.limit};
      tgt  = {cfg.tgt_hi, cfg.tgt_lo};
      if (cfg.bar_mode) begin
         win_ok = (req_bar == cfg.bar);
         ofs    = {{(ADDR_W-ALIGN_BITS){1'b0}}, req_addr[ALIGN_BITS-1:0]};
      end else begin
         win_ok = (req_addr >= base) && (req_addr <= lim);
         ofs    = req_addr - base;
      end
      hit   = cfg.en && (req_type == cfg.ttype) && win_ok;
      xaddr = tgt + ofs;
   end
endmodule

// File: rtl/xlate_select.sv
`timescale 1ns/1ps
module xlate_select
   import axu_pkg::*;
#(
   parameter int NUM_IB = 4,
   parameter int IDX_W  = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   input  logic [ADDR_W-1:0]               req_addr,
   input  logic [NUM_IB-1:0]               hit_vec,
   input  logic [NUM_IB-1:0][ADDR_W-1:0]   xaddr,
   output logic                            out_valid,
   output logic                            out_hit,
   output logic                            out_miss,
   output logic [IDX_W-1:0]                out_region,
   output logic [ADDR_W-1:0]               out_addr
);
   logic              any;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] sel_addr;
   logic [NUM_IB-1:0] lower_mask;

   // Descending scan: the lowest-numbered hit is assigned last
   always_comb begin
      any      = 1'b0;
      idx      = '0;
      sel_addr = req_addr;
      for (int i = NUM_IB - 1; i >= 0; i--)
         if (hit_vec[i]) begin
            any      = 1'b1;
            idx      = IDX_W'(i);
            sel_addr = xaddr[i];
         end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_hit    <= 1'b0;
         out_miss   <= 1'b0;
         out_region <= '0;
         out_addr   <= '0;
      end else begin
         out_valid  <= req_valid;
         out_hit    <= req_valid && any;
         out_miss   <= req_valid && !any;
         out_region <= any ? idx : '0;
         out_addr   <= sel_addr;
      end
   end

   assign lower_mask = ~({NUM_IB{1'b1}} << out_region);

   p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);
   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!out_valid && !out_hit && !out_miss));
   p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_hit != out_miss));
   p_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_miss |-> out_addr == $past(req_addr));
   p_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_hit |-> ((($past(hit_vec) & lower_mask) == '0) &&
                   (|($past(hit_vec) & (NUM_IB'(1) << out_region)))));
endmodule

// File: rtl/addr_xlate_unit.sv
`timescale 1ns/1ps
module addr_xlate_unit
   import axu_pkg::*;
#(
   parameter int NUM_IB     = 4,
   parameter int NUM_OB     = 4,
   parameter int ALIGN_BITS = 16,
   localparam int IDX_W     = (NUM_IB > 1) ? $clog2(NUM_IB) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [2:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               req_valid,
   input  logic [63:0]        req_addr,
   input  logic [3:0]         req_type,
   input  logic [2:0]         req_bar,
   output logic               out_valid,
   output logic               out_hit,
   output logic               out_miss,
   output logic [IDX_W-1:0]   out_region,
   output logic [63:0]        out_addr
);
   if (NUM_IB < 1 || NUM_IB > 16) begin : g_bad_ib
      $error("NUM_IB must be within 1..16");
   end
   if (NUM_OB < 1 || NUM_OB > 16) begin : g_bad_ob
      $error("NUM_OB must be within 1..16");
   end
   if (ALIGN_BITS < 1 || ALIGN_BITS > 31) begin : g_bad_align
      $error("ALIGN_BITS must be within 1..31");
   end

   region_t [NUM_IB-1:0]             ib_cfg;
   logic    [NUM_IB-1:0]             hit_vec;
   logic    [NUM_IB-1:0]             en_vec;
   logic    [NUM_IB-1:0][ADDR_W-1:0] xaddr;

   xlate_regfile #(
      .NUM_IB(NUM_IB), .NUM_OB(NUM_OB), .ALIGN_BITS(ALIGN_BITS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ib_cfg(ib_cfg)
   );

   for (genvar i = 0; i < NUM_IB; i++) begin : g_match
      xlate_region_match #(.ALIGN_BITS(ALIGN_BITS)) u_match (
         .cfg(ib_cfg[i]), .req_addr(req_addr), .req_type(req_type),
         .req_bar(req_bar), .hit(hit_vec[i]), .xaddr(xaddr[i])
      );
      assign en_vec[i] = ib_cfg[i].en;
   end

   xlate_select #(.NUM_IB(NUM_IB), .IDX_W(IDX_W)) u_sel (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr),
      .hit_vec(hit_vec), .xaddr(xaddr),
      .out_valid(out_valid), .out_hit(out_hit), .out_miss(out_miss),
      .out_region(out_region), .out_addr(out_addr)
   );

   // R6: a reported region was enabled when the request was sampled
   p_enabled_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_hit |-> |($past(en_vec) & (NUM_IB'(1) << out_region)));
endmodule

// File: tb/addr_xlate_unit_test.sv
`timescale 1ns/1ps
module addr_xlate_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = '0;
   logic [3:0]  req_type = '0;
   logic [2:0]  req_bar = '0;
   logic        out_valid, out_hit, out_miss;
   logic [1:0]  out_region;
   logic [63:0] out_addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   addr_xlate_unit uut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_addr(req_addr), .req_type(req_type),
      .req_bar(req_bar),
      .out_valid(out_valid), .out_hit(out_hit), .out_miss(out_miss),
      .out_region(out_region), .out_addr(out_addr)
   );

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic send(logic [63:0] a, logic [3:0] t, logic [2:0] b);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_type = t; req_bar = b;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic prog(logic [31:0] vp, logic [31:0] blo, logic [31:0] bhi,
                       logic [31:0] lim, logic [31:0] tlo, logic [31:0] thi,
                       logic [31:0] typ, logic [31:0] ctl);
      wr(3'd0, vp);
      wr(3'd3, blo); wr(3'd4, bhi); wr(3'd5, lim);
      wr(3'd6, tlo); wr(3'd7, thi);
      wr(3'd1, typ); wr(3'd2, ctl);
   endtask

   task automatic expect_hit(string req, logic [1:0] reg_i, logic [63:0] a);
      check(req, {63'd0, out_valid}, 64'd1);
      check(req, {63'd0, out_hit}, 64'd1);
      check(req, {62'd0, out_region}, {62'd0, reg_i});
      check(req, out_addr, a);
   endtask

   task automatic expect_miss(string req, logic [63:0] a);
      check(req, {62'd0, out_hit, out_miss}, 64'd1);
      check(req, out_addr, a);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 out_valid", {63'd0, out_valid}, 64'd0);
      check("R1 flags", {62'd0, out_hit, out_miss}, 64'd0);
      rd(3'd0, d); check("R1 selector", {32'd0, d}, 64'd0);
      rd(3'd3, d); check("R1 base", {32'd0, d}, 64'd0);
      send(64'h9050_0000, 4'd0, 3'd0);
      expect_miss("R1 disabled miss", 64'h9050_0000);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr(3'd0, 32'h8000_0002);
      wr(3'd3, 32'h1234_5678);
      rd(3'd3, d); check("R3 base align", {32'd0, d}, 64'h1234_0000);
      wr(3'd6, 32'hABCD_EF01);
      rd(3'd6, d); check("R3 target align", {32'd0, d}, 64'hABCD_0000);
      wr(3'd5, 32'h1234_FFFF);
      rd(3'd5, d); check("R3 limit full", {32'd0, d}, 64'h1234_FFFF);
      rd(3'd0, d); check("R2 selector", {32'd0, d}, 64'h8000_0002);
      wr(3'd0, 32'h7FFF_FFF2);
      rd(3'd0, d); check("R2 reserved", {32'd0, d}, 64'h0000_0002);
      rd(3'd3, d); check("R11 outbound separate", {32'd0, d}, 64'd0);
      wr(3'd0, 32'h8000_000F);
      wr(3'd3, 32'h5555_0000);
      rd(3'd3, d); check("R2 out of range", {32'd0, d}, 64'd0);
      // clear inbound region 2 again
      wr(3'd0, 32'h8000_0002);
      wr(3'd3, 32'd0); wr(3'd5, 32'd0); wr(3'd6, 32'd0);
   endtask

   task automatic t_addr();
      prog(32'h8000_0000, 32'h9050_0000, 32'd0, 32'h9050_FFFF,
           32'h2010_0000, 32'd0, 32'd0, 32'h8000_0000);
      send(64'h9050_0000, 4'd0, 3'd0); expect_hit("R4 first", 2'd0, 64'h2010_0000);
      send(64'h9050_FFFF, 4'd0, 3'd0); expect_hit("R4 last", 2'd0, 64'h2010_FFFF);
      send(64'h9051_0000, 4'd0, 3'd0); expect_miss("R4 above", 64'h9051_0000);
      send(64'h904F_FFFF, 4'd0, 3'd0); expect_miss("R4 below", 64'h904F_FFFF);
      send(64'h1_9050_0000, 4'd0, 3'd0); expect_miss("R4 upper bits", 64'h1_9050_0000);
   endtask

   task automatic t_type();
      send(64'h9050_0010, 4'd2, 3'd0); expect_miss("R5 type mismatch", 64'h9050_0010);
      send(64'h9050_0010, 4'd0, 3'd0); expect_hit("R5 type match", 2'd0, 64'h2010_0010);
   endtask

   task automatic t_enable();
      wr(3'd0, 32'h8000_0000); wr(3'd2, 32'h0);
      send(64'h9050_0040, 4'd0, 3'd0); expect_miss("R6 disabled", 64'h9050_0040);
      wr(3'd2, 32'h8000_0000);
      send(64'h9050_0040, 4'd0, 3'd0); expect_hit("R6 re-enabled", 2'd0, 64'h2010_0040);
   endtask

   task automatic t_priority();
      prog(32'h8000_0002, 32'h9050_0000, 32'd0, 32'h9050_FFFF,
           32'h3000_0000, 32'd0, 32'd0, 32'h8000_0000);
      send(64'h9050_0020, 4'd0, 3'd0); expect_hit("R8 lowest wins", 2'd0, 64'h2010_0020);
      wr(3'd0, 32'h8000_0000); wr(3'd2, 32'h0);
      send(64'h9050_0020, 4'd0, 3'd0); expect_hit("R8 next region", 2'd2, 64'h3000_0020);
      wr(3'd2, 32'h8000_0000);
   endtask

   task automatic t_bar();
      prog(32'h8000_0001, 32'd0, 32'd0, 32'd0,
           32'h4000_0000, 32'h1, 32'd0, 32'hC000_0200);
      send(64'hABCD_1234, 4'd0, 3'd2); expect_hit("R7 bar match", 2'd1, 64'h1_4000_1234);
      send(64'hABCD_1234, 4'd0, 3'd3); expect_miss("R7 bar mismatch", 64'hABCD_1234);
   endtask

   task automatic t_outbound();
      logic [31:0] d;
      prog(32'h0000_0000, 32'h7000_0000, 32'd0, 32'h7000_FFFF,
           32'h6000_0000, 32'd0, 32'd0, 32'h8000_0000);
      send(64'h7000_0010, 4'd0, 3'd0); expect_miss("R11 outbound inert", 64'h7000_0010);
      rd(3'd2, d); check("R11 outbound ctrl", {32'd0, d}, 64'h8000_0000);
      wr(3'd0, 32'h8000_0000);
      rd(3'd3, d); check("R11 inbound base kept", {32'd0, d}, 64'h9050_0000);
   endtask

   task automatic t_latency();
      @(negedge clk);
      req_valid = 1'b1; req_addr = 64'h9050_0100; req_type = 4'd0;
      #1 check("R10 no comb path", {63'd0, out_valid}, 64'd0);
      @(negedge clk);
      req_valid = 1'b0;
      expect_hit("R10 one cycle", 2'd0, 64'h2010_0100);
      @(negedge clk);
      check("R10 drops", {61'd0, out_valid, out_hit, out_miss}, 64'd0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_addr();
      t_type();
      t_enable();
      t_priority();
      t_bar();
      t_outbound();
      t_latency();
      finish_run();
   end
endmodule